// File: doc/BRIEF.md
# Radio Packet Receive Deframer

This block rebuilds packets from the bit stream a demodulator recovers. Bits arrive one at a time on a valid/ready stream. The block first hunts for an alternating preamble of programmable length. It then compares the bits that follow against a programmed address of one to four 16-bit words. On a full match it takes in a payload of programmed length. It removes the whitening from the payload, keeps up to 64 bytes in a local buffer, and checks the 16-bit CRC that trails the payload.

When a packet completes, the block raises a ready flag, along with CRC-error and overflow flags where they apply. The host then drains the stored bytes through a second valid/ready stream. The bit input is back-pressured while a finished packet is waiting: `bit_ready` stays low from the moment the packet completes until its last byte has been taken. A bit moves only in a cycle where `bit_valid` and `bit_ready` are both high. On the output side, `out_data` and `out_last` stay unchanged while `out_valid` is high and `out_ready` is low. A packet whose address does not match is dropped without any trace at the ports. The configuration inputs must stay stable while a packet is being received.

Top module: `pkt_rx_deframer`

## Requirements
- R1: Address checking starts only after (cfg_pre_bytes+1)*8 consecutive accepted bits in which each bit differs from the one before it. A shorter alternating run never leads to a packet.
- R2: The next 16*(cfg_addr_words+1) accepted bits are compared, most significant first, with the low bits of cfg_addr. At the first differing bit the packet is dropped silently and the preamble hunt resumes; no flag changes.
- R3: With cfg_white_en high, each payload bit is XORed with key = s[6]^s[3] of a 7-bit register s. The register is loaded with cfg_white_seed when the preamble is found, and it shifts left, taking in key, once per payload bit. With cfg_white_en low, payload bits pass through unchanged.
- R4: The payload is cfg_len+1 bytes, each sent most significant bit first. Only the first 64 bytes are stored. overflow is raised with the ready flag when cfg_len >= 64.
- R5: A CRC-16 (polynomial 0x1021, initial value 0xFFFF, bit-serial, most significant first) runs over the address bits, the de-whitened payload bits, and then the 16 trailing CRC bits, which are not whitened. crc_err is raised with the ready flag when the final value is nonzero.
- R6: pkt_ready rises in the cycle after the last CRC bit is accepted. It stays high until the buffer has been drained, and bit_ready is low for that whole time.
- R7: out_valid presents the stored bytes in arrival order, with out_last marking the final stored byte. out_data and out_last hold steady while out_ready is low.
- R8: Once the last byte has been taken, pkt_ready, crc_err and overflow are all low and bit_ready is high in the next cycle.
- R9: After reset, bit_ready is 1 and out_valid, pkt_ready, crc_err and overflow are 0.
- R10: Cycles in which bit_valid is low have no effect, whatever bit_data carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pre_bytes | input | 3 | Preamble length minus one, in bytes |
| cfg_addr_words | input | 2 | Address length minus one, in 16-bit words |
| cfg_addr | input | 64 | Expected address, right-aligned |
| cfg_len | input | 8 | Payload length minus one, in bytes |
| cfg_white_en | input | 1 | Enables payload de-whitening |
| cfg_white_seed | input | 7 | De-whitening register start value |
| bit_valid | input | 1 | Received bit is valid |
| bit_data | input | 1 | Received bit |
| bit_ready | output | 1 | Block can accept a bit |
| out_valid | output | 1 | Stored byte available |
| out_data | output | 8 | Stored byte |
| out_last | output | 1 | Final stored byte of the packet |
| out_ready | input | 1 | Host takes the byte |
| pkt_ready | output | 1 | Packet complete and waiting in the buffer |
| crc_err | output | 1 | Completed packet failed its CRC |
| overflow | output | 1 | Payload was longer than the buffer |

## Verification
The hardest case to reach from the ports is a silent address drop followed at once by a clean capture. Nothing at the outputs reports the drop, and a stale alternating run left in the hunter could make the next preamble count too early. The stimulus sends a preamble and a wrong address with the rest of the packet cut off. Two equal guard bits follow to break any run. A valid packet comes straight after, and its payload must come out intact. Payloads longer than the buffer and whitened bursts with idle gaps are driven through the same bit-level packet builder.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [1:0] {ST_HUNT, ST_ADDR, ST_PAY, ST_CRC} rx_state_t;

  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic b,
                                            input logic [15:0] poly);
    logic fb;
    fb = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (fb ? poly : 16'h0000);
  endfunction
endpackage

// File: rtl/rxd_pre_hunt.sv
module rxd_pre_hunt #(
  parameter int RUN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             shift,
  input  logic             bit_in,
  input  logic [RUN_W-1:0] need,
  output logic             found
);
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  logic [RUN_W-1:0] run, run_nxt;
  logic             prev, have_prev;

  always_comb begin
    if (!have_prev || bit_in == prev) run_nxt = RUN_W'(1);
    else if (run == RUN_MAX)          run_nxt = run;
    else                              run_nxt = run + 1'b1;
  end

  assign found = shift && (run_nxt >= need);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      run       <= '0;
      prev      <= 1'b0;
      have_prev <= 1'b0;
    end else if (shift) begin
      run       <= run_nxt;
      prev      <= bit_in;
      have_prev <= 1'b1;
    end
  end
endmodule

// File: rtl/rxd_crc16.sv
module rxd_crc16 #(
  parameter logic [15:0] POLY = 16'h1021,
  parameter logic [15:0] INIT = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        en,
  input  logic        bit_in,
  output logic [15:0] crc_nxt
);
  import rxd_pkg::*;

  logic [15:0] crc_q;

  assign crc_nxt = crc16_step(crc_q, bit_in, POLY);

  always_ff @(posedge clk) begin
    if (!rst_n || init) crc_q <= INIT;
    else if (en)        crc_q <= crc_nxt;
  end
endmodule

// File: rtl/rxd_whiten.sv
module rxd_whiten #(
  parameter int LFSR_W = 7,
  parameter int TAP_HI = 6,
  parameter int TAP_LO = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LFSR_W-1:0] seed,
  input  logic              step,
  output logic              key
);
  logic [LFSR_W-1:0] s;

  assign key = s[TAP_HI] ^ s[TAP_LO];

  always_ff @(posedge clk) begin
    if (!rst_n)    s <= '0;
    else if (load) s <= seed;
    else if (step) s <= {s[LFSR_W-2:0], key};
  end
endmodule

// File: rtl/rxd_rx_buffer.sv
module rxd_rx_buffer #(
  parameter int DEPTH = 64,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             pkt_done,
  input  logic [CNT_W-1:0] count_in,
  input  logic             hold,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic             drained
);
  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr;
  logic [CNT_W-1:0] count;

  assign out_valid = hold;
  assign out_data  = mem[rd_ptr];
  assign out_last  = ({1'b0, rd_ptr} == count - CNT_W'(1));
  assign drained   = out_valid && out_ready && out_last;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (pkt_done) count <= count_in;
      if (out_valid && out_ready) rd_ptr <= out_last ? '0 : rd_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/pkt_rx_deframer.sv
module pkt_rx_deframer #(
  parameter int PRE_BYTES_MAX  = 8,
  parameter int WORD_W         = 16,
  parameter int ADDR_WORDS_MAX = 4,
  parameter int LEN_W          = 8,
  parameter int BUF_BYTES      = 64,
  parameter int SEED_W         = 7
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [$clog2(PRE_BYTES_MAX)-1:0]      cfg_pre_bytes,
  input  logic [$clog2(ADDR_WORDS_MAX)-1:0]     cfg_addr_words,
  input  logic [WORD_W*ADDR_WORDS_MAX-1:0]      cfg_addr,
  input  logic [LEN_W-1:0]                      cfg_len,
  input  logic                                  cfg_white_en,
  input  logic [SEED_W-1:0]                     cfg_white_seed,
  input  logic                                  bit_valid,
  input  logic                                  bit_data,
  output logic                                  bit_ready,
  output logic                                  out_valid,
  output logic [7:0]                            out_data,
  output logic                                  out_last,
  input  logic                                  out_ready,
  output logic                                  pkt_ready,
  output logic                                  crc_err,
  output logic                                  overflow
);
  import rxd_pkg::*;

  localparam int ADDR_W = WORD_W * ADDR_WORDS_MAX;
  localparam int AIDX_W = $clog2(ADDR_W);
  localparam int ABIT_W = $clog2(ADDR_W + 1);
  localparam int RUN_W  = $clog2(PRE_BYTES_MAX * 8 + 1);
  localparam int PTR_W  = $clog2(BUF_BYTES);
  localparam int CNT_W  = $clog2(BUF_BYTES + 1);
  localparam logic [LEN_W:0] BUF_LIM = (LEN_W+1)'(BUF_BYTES);

  rx_state_t         state;
  logic [AIDX_W-1:0] bit_idx;
  logic [2:0]        bitcnt;
  logic [LEN_W-1:0]  byte_idx;
  logic [6:0]        shreg;
  logic [3:0]        crc_cnt;

  logic              acc, found, wkey, d_bit, exp_bit, drained, pkt_done, is_long;
  logic [RUN_W-1:0]  need;
  logic [ABIT_W-1:0] addr_bits;
  logic [AIDX_W-1:0] sel;
  logic [15:0]       crc_nxt;
  logic [CNT_W-1:0]  stored;

  assign bit_ready = !pkt_ready;
  assign acc       = bit_valid && bit_ready;
  assign need      = RUN_W'((32'(cfg_pre_bytes) + 1) * 8);
  assign addr_bits = ABIT_W'((32'(cfg_addr_words) + 1) * WORD_W);
  assign sel       = AIDX_W'(addr_bits - ABIT_W'(1) - {1'b0, bit_idx});
  assign exp_bit   = cfg_addr[sel];
  assign d_bit     = bit_data ^ (cfg_white_en & wkey);
  assign pkt_done  = acc && state == ST_CRC && crc_cnt == 4'd15;
  assign is_long   = ({1'b0, cfg_len} >= BUF_LIM);
  assign stored    = is_long ? CNT_W'(BUF_BYTES) : CNT_W'(cfg_len) + CNT_W'(1);

  rxd_pre_hunt #(.RUN_W(RUN_W)) u_hunt (
    .clk, .rst_n,
    .clear  (state != ST_HUNT),
    .shift  (acc && state == ST_HUNT),
    .bit_in (bit_data),
    .need,
    .found
  );

  rxd_crc16 u_crc (
    .clk, .rst_n,
    .init    (found),
    .en      (acc && (state == ST_PAY || state == ST_CRC ||
                      (state == ST_ADDR && bit_data == exp_bit))),
    .bit_in  (state == ST_PAY ? d_bit : bit_data),
    .crc_nxt
  );

  rxd_whiten #(.LFSR_W(SEED_W)) u_white (
    .clk, .rst_n,
    .load (found),
    .seed (cfg_white_seed),
    .step (acc && state == ST_PAY),
    .key  (wkey)
  );

  rxd_rx_buffer #(.DEPTH(BUF_BYTES)) u_buf (
    .clk, .rst_n,
    .wr_en    (acc && state == ST_PAY && bitcnt == 3'd7 && {1'b0, byte_idx} < BUF_LIM),
    .wr_addr  (PTR_W'(byte_idx)),
    .wr_data  ({shreg, d_bit}),
    .pkt_done,
    .count_in (stored),
    .hold     (pkt_ready),
    .out_ready,
    .out_valid,
    .out_data,
    .out_last,
    .drained
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_HUNT;
      bit_idx   <= '0;
      bitcnt    <= '0;
      byte_idx  <= '0;
      shreg     <= '0;
      crc_cnt   <= '0;
      pkt_ready <= 1'b0;
      crc_err   <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      if (drained) begin
        pkt_ready <= 1'b0;
        crc_err   <= 1'b0;
        overflow  <= 1'b0;
      end
      if (acc) begin
        unique case (state)
          ST_HUNT: if (found) begin
            state   <= ST_ADDR;
            bit_idx <= '0;
          end
          ST_ADDR: begin
            if (bit_data != exp_bit) state <= ST_HUNT;
            else if ({1'b0, bit_idx} == addr_bits - ABIT_W'(1)) begin
              state    <= ST_PAY;
              bitcnt   <= '0;
              byte_idx <= '0;
            end else bit_idx <= bit_idx + 1'b1;
          end
          ST_PAY: begin
            shreg  <= {shreg[5:0], d_bit};
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == 3'd7) begin
              byte_idx <= byte_idx + 1'b1;
              if (byte_idx == cfg_len) begin
                state   <= ST_CRC;
                crc_cnt <= '0;
              end
            end
          end
          ST_CRC: begin
            crc_cnt <= crc_cnt + 1'b1;
            if (crc_cnt == 4'd15) begin
              state     <= ST_HUNT;
              pkt_ready <= 1'b1;
              crc_err   <= (crc_nxt != 16'h0000);
              overflow  <= is_long;
            end
          end
          default: state <= ST_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/pkt_rx_deframer_chk.sv
module pkt_rx_deframer_chk #(
  parameter int LEN_W     = 8,
  parameter int BUF_BYTES = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_valid,
  input logic             bit_ready,
  input logic [LEN_W-1:0] cfg_len,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             out_last,
  input logic             pkt_ready,
  input logic             crc_err,
  input logic             overflow
);
  assert_hold_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  assert_ready_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ready && !(out_valid && out_ready && out_last) |=> pkt_ready && !bit_ready);

  assert_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_ready) |-> $past(bit_valid && bit_ready));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !pkt_ready && !crc_err && !overflow && bit_ready);

  assert_crc_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |-> pkt_ready);

  assert_ovf_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_ready) |-> overflow == ({1'b0, $past(cfg_len)} >= (LEN_W+1)'(BUF_BYTES)));
endmodule

bind pkt_rx_deframer pkt_rx_deframer_chk #(.LEN_W(LEN_W), .BUF_BYTES(BUF_BYTES)) i_chk (
  .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_ready(bit_ready),
  .cfg_len(cfg_len), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last), .pkt_ready(pkt_ready),
  .crc_err(crc_err), .overflow(overflow)
);

// File: tb/test_pkt_rx_deframer.sv
module test_pkt_rx_deframer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_pre_bytes = '0;
  logic [1:0]  cfg_addr_words = '0;
  logic [63:0] cfg_addr = '0;
  logic [7:0]  cfg_len = '0;
  logic        cfg_white_en = 1'b0;
  logic [6:0]  cfg_white_seed = '0;
  logic        bit_valid = 1'b0, bit_data = 1'b0, out_ready = 1'b0;
  logic        bit_ready, out_valid, out_last, pkt_ready, crc_err, overflow;
  logic [7:0]  out_data;

  int n_chk = 0, n_fail = 0;
  bit tx_q[$];
  logic [7:0] pl [256];

  always #5 clk = ~clk;

  pkt_rx_deframer i_pkt_rx_deframer (.*);

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bit_valid = 1'b0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  function automatic logic [15:0] crc_bit(input logic [15:0] c, input bit b);
    return (c[15] ^ b) ? ({c[14:0], 1'b0} ^ 16'h1021) : {c[14:0], 1'b0};
  endfunction

  // Packet builder from R1..R5: guard 00, preamble 0x55 bytes, address,
  // payload (whitened per R3), CRC over address and plain payload.
  task automatic build(input int pre, input logic [63:0] a, input int words,
                       input int nbytes, input bit wen, input logic [6:0] seed,
                       input bit bad);
    logic [15:0] c = 16'hFFFF;
    logic [6:0]  s = seed;
    tx_q.delete();
    tx_q.push_back(1'b0); tx_q.push_back(1'b0);
    for (int i = 0; i < pre * 8; i++) tx_q.push_back(bit'(i % 2));
    for (int k = 0; k < 16 * words; k++) begin
      tx_q.push_back(a[16 * words - 1 - k]);
      c = crc_bit(c, a[16 * words - 1 - k]);
    end
    for (int i = 0; i < nbytes; i++)
      for (int j = 7; j >= 0; j--) begin
        bit w = s[6] ^ s[3];
        s = {s[5:0], w};
        c = crc_bit(c, pl[i][j]);
        tx_q.push_back(pl[i][j] ^ (wen & w));
      end
    for (int j = 15; j >= 0; j--) tx_q.push_back(c[j] ^ (bad && j == 15));
  endtask

  task automatic send_q(input int gap, input int nbits);
    int lim = (nbits < 0) ? tx_q.size() : nbits;
    for (int i = 0; i < lim; i++) begin
      if (gap > 0 && i % gap == 0) begin
        bit_valid = 1'b0; bit_data = 1'($urandom);
        @(posedge clk); #1;
      end
      bit_valid = 1'b1; bit_data = tx_q[i];
      @(posedge clk); #1;
      bit_valid = 1'b0;
    end
  endtask

  task automatic drain(input int n, input int stall_at, input string req);
    for (int i = 0; i < n; i++) begin
      if (i == stall_at) begin
        logic [7:0] held = out_data;
        out_ready = 1'b0;
        repeat (3) @(posedge clk);
        #1 chk("R7", "stall hold", {out_valid, out_data}, {1'b1, held});
      end
      out_ready = 1'b1;
      chk(req, $sformatf("byte %0d", i), out_data, pl[i]);
      chk("R7", $sformatf("last at %0d", i), {out_valid, out_last}, {1'b1, 1'(i == n - 1)});
      @(posedge clk); #1;
      out_ready = 1'b0;
    end
    chk("R8", "clear after drain", {pkt_ready, crc_err, overflow, bit_ready}, 4'b0001);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R9", "reset outputs", {bit_ready, out_valid, pkt_ready, crc_err, overflow}, 5'b10000);
  endtask

  task automatic t_basic();
    do_reset();
    cfg_pre_bytes = 3'd0; cfg_addr_words = 2'd0; cfg_addr = 64'h1234;
    cfg_len = 8'd3; cfg_white_en = 1'b0;
    for (int i = 0; i < 4; i++) pl[i] = 8'(8'hA1 + i * 17);
    build(1, 64'h1234, 1, 4, 1'b0, 7'h0, 1'b0);
    send_q(0, -1);
    chk("R6", "ready after crc", {pkt_ready, bit_ready}, 2'b10);
    chk("R5", "good crc", {crc_err, overflow}, 2'b00);
    drain(4, 2, "R4");
  endtask

  task automatic t_whiten_gaps();
    do_reset();
    cfg_pre_bytes = 3'd7; cfg_addr_words = 2'd3; cfg_addr = 64'h1234_5678_9ABC_DEF0;
    cfg_len = 8'd19; cfg_white_en = 1'b1; cfg_white_seed = 7'h5A;
    for (int i = 0; i < 20; i++) pl[i] = 8'(i * 37 + 5);
    build(8, cfg_addr, 4, 20, 1'b1, 7'h5A, 1'b0);
    send_q(3, -1);
    chk("R1", "8-byte preamble, 4-word address", pkt_ready, 1'b1);
    chk("R10", "gaps ignored, crc ok", crc_err, 1'b0);
    drain(20, -1, "R3");
  endtask

  task automatic t_crc_bad();
    do_reset();
    cfg_pre_bytes = 3'd1; cfg_addr_words = 2'd1; cfg_addr = 64'hBEEF_0042;
    cfg_len = 8'd5; cfg_white_en = 1'b0;
    for (int i = 0; i < 6; i++) pl[i] = 8'(i * 29 + 3);
    build(2, cfg_addr, 2, 6, 1'b0, 7'h0, 1'b1);
    send_q(0, -1);
    chk("R5", "corrupted crc flagged", {pkt_ready, crc_err}, 2'b11);
    drain(6, -1, "R5");
  endtask

  task automatic t_overflow();
    do_reset();
    cfg_pre_bytes = 3'd0; cfg_addr_words = 2'd0; cfg_addr = 64'h5A5A;
    cfg_len = 8'd69; cfg_white_en = 1'b1; cfg_white_seed = 7'h11;
    for (int i = 0; i < 70; i++) pl[i] = 8'(i * 13 + 7);
    build(1, cfg_addr, 1, 70, 1'b1, 7'h11, 1'b0);
    send_q(0, -1);
    chk("R4", "overflow flag", {pkt_ready, overflow}, 2'b11);
    chk("R5", "crc over full payload", crc_err, 1'b0);
    drain(64, 10, "R4");
  endtask

  task automatic t_short_pre();
    do_reset();
    cfg_pre_bytes = 3'd2; cfg_addr_words = 2'd0; cfg_addr = 64'h1234;
    cfg_len = 8'd1; cfg_white_en = 1'b0;
    pl[0] = 8'h00; pl[1] = 8'h00;
    build(2, 64'h1234, 1, 2, 1'b0, 7'h0, 1'b0);
    send_q(0, -1);
    repeat (4) @(posedge clk);
    #1 chk("R1", "short preamble rejected", {pkt_ready, bit_ready}, 2'b01);
  endtask

  task automatic t_addr_miss();
    do_reset();
    cfg_pre_bytes = 3'd0; cfg_addr_words = 2'd0; cfg_addr = 64'hC3A5;
    cfg_len = 8'd2; cfg_white_en = 1'b0;
    for (int i = 0; i < 3; i++) pl[i] = 8'(8'h3C + i);
    build(1, 64'h0F0F, 1, 3, 1'b0, 7'h0, 1'b0);
    send_q(0, 2 + 8 + 16);
    repeat (2) @(posedge clk);
    #1 chk("R2", "mismatch silent", {pkt_ready, crc_err, overflow, bit_ready}, 4'b0001);
    build(1, 64'hC3A5, 1, 3, 1'b0, 7'h0, 1'b0);
    send_q(0, -1);
    chk("R2", "resume after drop", {pkt_ready, crc_err}, 2'b10);
    drain(3, -1, "R2");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_whiten_gaps();
    t_crc_bad();
    t_overflow();
    t_short_pre();
    t_addr_miss();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule